// File: doc/BRIEF.md
# IDE Channel I/O Address Decoder

This block places the two register windows of each of two ATA channels (primary and secondary) into I/O space and decides, for every I/O cycle, whether a drive register is being addressed. Each channel owns an 8-byte command window and a 4-byte control window. Four base registers hold their positions and are reached through a small configuration port. Each channel has a mode bit. With the bit clear, the channel uses its fixed compatibility addresses. With the bit set, it uses whatever base software has programmed.

The decode path is purely combinational. It takes the dword address and byte enables of an I/O cycle, together with the register contents, and produces a claim, the channel that was hit, and one of two drive chip selects. The command window drives the first chip select and the control window drives the second. A control window claims only the single byte at lane 2 of its dword. Software sizes a window in the usual way: it writes all ones to the register and reads back a mask in which the read-only low bits show the window length and the I/O-space marker.

Top module: `ide_io_decode`

## Requirements
- R1: After reset the base registers read 0x000001F1 at offset 10h, 0x000003F5 at 14h, 0x00000171 at 18h and 0x00000375 at 1Ch. All values are truncated to ADDR_W bits.
- R2: Bit 0 of every base register reads 1. Bits [2:1] of the command registers (10h, 18h) and bit [1] of the control registers (14h, 1Ch) always read 0. After all ones are written, the command registers read 0xFFFFFFF9 and the control registers read 0xFFFFFFFD.
- R3: A configuration write updates only the bytes whose cfg_be bit is set, and the new value is visible after the next rising clock edge. Offsets other than the four base registers read 0 and ignore writes.
- R4: A write to a channel's registers is ignored while that channel's native_mode bit is 0. Bit 0 of native_mode selects the primary channel and bit 1 the secondary.
- R5: In compatibility mode the primary channel decodes 1F0h–1F7h as command and 3F6h as control. The secondary channel decodes 170h–177h as command and 376h as control. These decodes ignore the register contents.
- R6: In native mode a channel decodes its command window at the programmed base rounded down to 8 bytes, and its control window at the programmed base rounded down to 4 bytes.
- R7: A command window hit needs at least one set bit in io_be. A control window hit needs io_be to equal exactly 4'b0100, which is byte lane 2. io_be = 0 never produces a hit.
- R8: A native-mode register whose address field is zero never produces a hit.
- R9: No window hits unless io_valid and io_en are both 1 and the chan_en bit of the window's channel is 1.
- R10: A command window hit raises cs0 and a control window hit raises cs1. chan_sel is 0 for the primary channel and 1 for the secondary. claim is 1 exactly when one of cs0 or cs1 is 1, and cs0 and cs1 are never both 1.
- R11: When windows overlap, the register with the lowest offset wins the cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_off | input | 6 | Configuration dword offset (byte offset bits [7:2]) |
| cfg_be | input | 4 | Configuration byte write enables |
| cfg_wdata | input | ADDR_W-2 | Write data, bits [ADDR_W-1:2] |
| cfg_rdata | output | ADDR_W | Read data of the addressed register |
| io_en | input | 1 | I/O space enable from the command register |
| chan_en | input | 2 | Per-channel enable (bit 0 primary) |
| native_mode | input | 2 | Per-channel native mode (bit 0 primary) |
| io_valid | input | 1 | An I/O cycle is present |
| io_addr | input | ADDR_W-2 | I/O dword address, bits [ADDR_W-1:2] |
| io_be | input | 4 | I/O byte enables, active high |
| claim | output | 1 | Cycle claimed |
| chan_sel | output | 1 | Channel hit (0 primary, 1 secondary) |
| cs0 | output | 1 | Command window chip select |
| cs1 | output | 1 | Control window chip select |

## Verification
The bench builds the block with ADDR_W = 16. Every register bit then fits in one configuration byte pair, and every window the bench programs lies below 400h. With that setting, each sweep covers every dword from 0 to 3FCh against all sixteen byte-enable patterns. The sweeps are repeated in several states: compatibility mode, native mode, mixed modes, zeroed bases, overlapping windows and each form of enable gating. Every lane of every window is therefore compared, including the unclaimed control-window bytes.

// File: rtl/ide_dec_pkg.sv
package ide_dec_pkg;
  localparam int NWIN         = 4;
  localparam int CMD_LOG2     = 3;
  localparam int CTL_LOG2     = 2;
  localparam int CTL_LANE     = 2;
  localparam int CFG_FIRST_DW = 4;

  function automatic logic [31:0] legacy_base(input int idx);
    case (idx)
      0:       return 32'h0000_01F0;
      1:       return 32'h0000_03F4;
      2:       return 32'h0000_0170;
      default: return 32'h0000_0374;
    endcase
  endfunction

  function automatic int win_log2(input int idx);
    return (idx % 2 == 0) ? CMD_LOG2 : CTL_LOG2;
  endfunction

  function automatic logic [3:0] lane_mask(input int idx);
    return (idx % 2 == 0) ? 4'b0000 : 4'(1 << CTL_LANE);
  endfunction
endpackage

// File: rtl/ide_base_reg.sv
module ide_base_reg #(
  parameter int AW = 32,
  parameter int WL = 3,
  parameter logic [AW-1:WL] RST_FIELD = '0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [3:0]    be,
  input  logic [AW-1:WL] wdata,
  output logic [AW-1:WL] field
);
  always_ff @(posedge clk) begin
    if (rst) begin
      field <= RST_FIELD;
    end else if (we) begin
      for (int b = WL; b < AW; b++) begin
        if (be[b / 8]) field[b] <= wdata[b];
      end
    end
  end

  // R4: without a write the stored base holds
  a_r4_hold: assert property (@(posedge clk) disable iff (rst)
    !we |=> $stable(field));
  // R3: a full-width write lands on the next edge
  a_r3_full_write: assert property (@(posedge clk) disable iff (rst)
    (we && be == 4'hF) |=> field == $past(wdata));
endmodule

// File: rtl/ide_win_match.sv
module ide_win_match #(
  parameter int AW = 32,
  parameter int WL = 3,
  parameter logic [3:0] LANE_MASK = 4'b0000
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           en,
  input  logic [AW-1:WL] addr,
  input  logic [3:0]     be,
  input  logic [AW-1:WL] base,
  output logic           hit
);
  logic lane_ok, base_ok, addr_ok;

  if (LANE_MASK == 4'b0000) begin : g_any_lane
    assign lane_ok = (be != 4'b0000);
  end else begin : g_one_lane
    assign lane_ok = (be == LANE_MASK);
  end

  assign base_ok = (base != '0);
  assign addr_ok = (addr == base);
  assign hit     = en && lane_ok && base_ok && addr_ok;

  // R9: no hit without enable
  a_r9_gated: assert property (@(posedge clk) disable iff (rst)
    hit |-> en);
  // R8: a zero base field never matches
  a_r8_zero_base: assert property (@(posedge clk) disable iff (rst)
    hit |-> (base != '0));
  // R7: a hit always carries at least one byte lane
  a_r7_lane: assert property (@(posedge clk) disable iff (rst)
    hit |-> (be != 4'b0000));
endmodule

// File: rtl/ide_hit_arb.sv
module ide_hit_arb #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] hit,
  output logic [N-1:0] grant
);
  assign grant = hit & (~hit + N'(1));

  // R11: at most one window wins, and only one that hit
  a_r11_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant));
  a_r11_subset: assert property (@(posedge clk) disable iff (rst)
    (grant & ~hit) == '0);
  a_r11_any: assert property (@(posedge clk) disable iff (rst)
    (hit != '0) |-> (grant != '0));
endmodule

// File: rtl/ide_io_decode.sv
module ide_io_decode
  import ide_dec_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [7:2]        cfg_off,
  input  logic [3:0]        cfg_be,
  input  logic [ADDR_W-1:2] cfg_wdata,
  output logic [ADDR_W-1:0] cfg_rdata,
  input  logic              io_en,
  input  logic [1:0]        chan_en,
  input  logic [1:0]        native_mode,
  input  logic              io_valid,
  input  logic [ADDR_W-1:2] io_addr,
  input  logic [3:0]        io_be,
  output logic              claim,
  output logic              chan_sel,
  output logic              cs0,
  output logic              cs1
);
  logic [NWIN-1:0]   hit;
  logic [NWIN-1:0]   grant;
  logic [ADDR_W-1:0] rd_arr [NWIN];

  for (genvar i = 0; i < NWIN; i++) begin : g_win
    localparam int WL = win_log2(i);
    localparam int CH = i / 2;
    localparam logic [ADDR_W-1:0] LB = ADDR_W'(legacy_base(i));
    localparam logic [ADDR_W-1:0] RV = ADDR_W'(legacy_base(i) | 32'h1);

    logic              wr_sel;
    logic              en;
    logic [ADDR_W-1:WL] field;
    logic [ADDR_W-1:WL] eff;

    assign wr_sel = cfg_we && (cfg_off == 6'(CFG_FIRST_DW + i)) && native_mode[CH];
    assign en     = io_valid && io_en && chan_en[CH];
    assign eff    = native_mode[CH] ? field : LB[ADDR_W-1:WL];

    ide_base_reg #(
      .AW(ADDR_W), .WL(WL), .RST_FIELD(RV[ADDR_W-1:WL])
    ) u_reg (
      .clk(clk), .rst(rst), .we(wr_sel), .be(cfg_be),
      .wdata(cfg_wdata[ADDR_W-1:WL]), .field(field)
    );

    ide_win_match #(
      .AW(ADDR_W), .WL(WL), .LANE_MASK(lane_mask(i))
    ) u_match (
      .clk(clk), .rst(rst), .en(en), .addr(io_addr[ADDR_W-1:WL]),
      .be(io_be), .base(eff), .hit(hit[i])
    );

    assign rd_arr[i] = {field, {(WL-1){1'b0}}, 1'b1};
  end

  always_comb begin
    cfg_rdata = '0;
    for (int i = 0; i < NWIN; i++) begin
      if (cfg_off == 6'(CFG_FIRST_DW + i)) cfg_rdata = rd_arr[i];
    end
  end

  ide_hit_arb #(.N(NWIN)) u_arb (
    .clk(clk), .rst(rst), .hit(hit), .grant(grant)
  );

  assign cs0      = grant[0] | grant[2];
  assign cs1      = grant[1] | grant[3];
  assign chan_sel = grant[2] | grant[3];
  assign claim    = |grant;

  // R10: the two chip selects never fire together
  a_r10_cs_excl: assert property (@(posedge clk) disable iff (rst)
    !(cs0 && cs1));
  // R9: a claim requires a valid, enabled I/O cycle
  a_r9_claim_en: assert property (@(posedge clk) disable iff (rst)
    claim |-> (io_valid && io_en));
  // R9: the selected channel must be enabled
  a_r9_chan_en: assert property (@(posedge clk) disable iff (rst)
    claim |-> chan_en[chan_sel]);
  // R2: every base register reads as I/O space
  a_r2_io_bit: assert property (@(posedge clk) disable iff (rst)
    (cfg_off >= 6'(CFG_FIRST_DW) && cfg_off < 6'(CFG_FIRST_DW + NWIN)) |-> cfg_rdata[0]);
endmodule

// File: tb/tb_ide_io_decode.sv
module tb_ide_io_decode;
  localparam int CLK_P = 10;
  localparam int AW    = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cfg_we = 1'b0;
  logic [7:2]    cfg_off = '0;
  logic [3:0]    cfg_be = '0;
  logic [AW-1:2] cfg_wdata = '0;
  logic [AW-1:0] cfg_rdata;
  logic          io_en = 1'b1;
  logic [1:0]    chan_en = 2'b11;
  logic [1:0]    native_mode = 2'b00;
  logic          io_valid = 1'b1;
  logic [AW-1:2] io_addr = '0;
  logic [3:0]    io_be = '0;
  logic          claim, chan_sel, cs0, cs1;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [15:0] leg [4] = '{16'h01F0, 16'h03F4, 16'h0170, 16'h0374};
  logic [15:0] mb  [4];

  ide_io_decode #(.ADDR_W(AW)) dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_off(cfg_off), .cfg_be(cfg_be),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .io_en(io_en),
    .chan_en(chan_en), .native_mode(native_mode), .io_valid(io_valid),
    .io_addr(io_addr), .io_be(io_be), .claim(claim), .chan_sel(chan_sel),
    .cs0(cs0), .cs1(cs1)
  );

  always #(CLK_P/2) clk = ~clk;

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input int idx, input logic [3:0] be, input logic [15:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_off = 6'(4 + idx); cfg_be = be; cfg_wdata = d[15:2];
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd(input int off_dw, input logic [15:0] exp, input string tag);
    @(negedge clk);
    cfg_off = 6'(off_dw);
    #1;
    check(tag, 32'(cfg_rdata), 32'(exp));
  endtask

  function automatic logic [3:0] model(input logic [13:0] a, input logic [3:0] be);
    logic [15:0] b;
    logic h;
    for (int i = 0; i < 4; i++) begin
      b = native_mode[i/2] ? mb[i] : leg[i];
      if (i % 2 == 0) h = (be != 0) && (a[13:1] == b[15:3]) && (b[15:3] != 0);
      else            h = (be == 4'b0100) && (a == b[15:2]) && (b[15:2] != 0);
      h = h && io_valid && io_en && chan_en[i/2];
      if (h) return {1'b1, (i >= 2), (i % 2 == 0), (i % 2 == 1)};
    end
    return 4'b0000;
  endfunction

  task automatic sweep(input string tag);
    for (int a = 0; a < 256; a++) begin
      for (int be = 0; be < 16; be++) begin
        io_addr = 14'(a); io_be = 4'(be);
        #1;
        check(tag, {28'd0, claim, chan_sel, cs0, cs1}, {28'd0, model(14'(a), 4'(be))});
      end
    end
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 4; i++) mb[i] = leg[i];
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;

    // R1 reset values
    rd(4, 16'h01F1, "R1 reg0");
    rd(5, 16'h03F5, "R1 reg1");
    rd(6, 16'h0171, "R1 reg2");
    rd(7, 16'h0375, "R1 reg3");
    // R3 unmapped offset
    rd(8, 16'h0000, "R3 unmapped read");

    // R5 R7 R10 compatibility decode
    sweep("R5/R7/R10 legacy sweep");

    // R4 writes ignored in compatibility mode
    for (int i = 0; i < 4; i++) wr(i, 4'hF, 16'hFFFF);
    rd(4, 16'h01F1, "R4 reg0 kept");
    rd(7, 16'h0375, "R4 reg3 kept");

    // R2 sizing
    native_mode = 2'b11;
    for (int i = 0; i < 4; i++) wr(i, 4'hF, 16'hFFFF);
    rd(4, 16'hFFF9, "R2 size reg0");
    rd(5, 16'hFFFD, "R2 size reg1");
    rd(6, 16'hFFF9, "R2 size reg2");
    rd(7, 16'hFFFD, "R2 size reg3");

    // R3 unmapped write ignored
    @(negedge clk);
    cfg_we = 1'b1; cfg_off = 6'h08; cfg_be = 4'hF; cfg_wdata = '0;
    @(negedge clk); cfg_we = 1'b0;
    rd(8, 16'h0000, "R3 unmapped write");
    rd(4, 16'hFFF9, "R3 reg0 untouched");

    // R6 native bases, low bits dropped (R2)
    wr(0, 4'hF, 16'h020F); mb[0] = 16'h0208;
    wr(1, 4'hF, 16'h02A7); mb[1] = 16'h02A4;
    wr(2, 4'hF, 16'h0310); mb[2] = 16'h0310;
    wr(3, 4'hF, 16'h0300); mb[3] = 16'h0300;
    rd(4, 16'h0209, "R2 reg0 low bits");
    rd(5, 16'h02A5, "R2 reg1 low bits");
    sweep("R6/R7/R10 native sweep");

    // mixed modes (R5 R6)
    native_mode = 2'b01;
    sweep("R5/R6 mixed sweep");
    native_mode = 2'b11;

    // R3 byte-enable write
    wr(2, 4'b0001, 16'hFFFF); mb[2] = 16'h03F8;
    rd(6, 16'h03F9, "R3 byte write");

    // R8 zero bases
    wr(1, 4'b0011, 16'h0000); mb[1] = 16'h0000;
    wr(0, 4'b0011, 16'h0000); mb[0] = 16'h0000;
    rd(5, 16'h0001, "R8 reg1 zero");
    sweep("R8 zero base sweep");

    // R11 overlap
    wr(0, 4'hF, 16'h0208); mb[0] = 16'h0208;
    wr(2, 4'hF, 16'h0208); mb[2] = 16'h0208;
    io_addr = 14'h0082; io_be = 4'b0001; #1;
    check("R11 overlap primary wins", {28'd0, claim, chan_sel, cs0, cs1}, 32'h0000_000A);
    sweep("R11 overlap sweep");

    // R9 gating
    io_valid = 1'b0; sweep("R9 no valid"); io_valid = 1'b1;
    io_en = 1'b0;    sweep("R9 io disabled"); io_en = 1'b1;
    chan_en = 2'b10; sweep("R9 primary off");
    chan_en = 2'b01; sweep("R9 secondary off");
    chan_en = 2'b11;

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule